// File: doc/BRIEF.md
# Push-Button Wiper Position Controller

This block turns two active-low push buttons into a saturating tap position for a digitally controlled resistor ladder. Each button input is synchronised and debounced. A single press moves the tap by one position. When a button is held, the step repeats, first at a slow period and then, after a longer hold, at a fast period. Pressing both buttons at the same time cancels movement. The one exception is a deliberate two-button hold, which puts the block into a low-power shutdown state. In that state the tap output reads zero and a flag tells the analog side to open the top of the resistor chain.

Shutdown ends on a debounced press of either movement button or of the store input, and the tap held before shutdown comes back unchanged. A freeze input holds the position while a non-volatile write is in progress. A load port restores a recalled position at power-up. A one-cycle strobe marks every step that actually moves the tap. All time constants are parameters counted in clock ticks.

Top module: `btnw_top`

## Requirements
- R1: The tap is a TAP_W-bit value (default 5, range 0..31) that comes out of reset at RESET_TAP (default 16). A step changes it by exactly one. It stops at 0 and at the top code and never wraps.
- R2: A button low for fewer than DEB_TICKS consecutive ticks (after a 2-flop synchroniser) is ignored: the tap does not move and no strobe is produced.
- R3: A single press of up_n raises the tap by one and a single press of dn_n lowers it by one. Each press produces exactly one step_o pulse. The step is taken DEB_TICKS ticks after the press is recognised, or earlier if the button is released first.
- R4: While one button stays held, further steps follow every SLOW_TICKS ticks. Once the hold has lasted FAST_AFTER ticks, steps follow every FAST_TICKS ticks.
- R5: After the held button is released, no further steps occur.
- R6: If the second button is recognised while the first is held, outside the pairing window, the block makes no further movement until both are released, however long they are held. Any step already taken by the first button stays. No shutdown follows.
- R7: If both buttons are recognised within DEB_TICKS ticks of each other and both stay held for SHDN_TICKS ticks, shdn_o goes to 1 and tap_o reads 0. A shorter simultaneous press moves nothing.
- R8: In shutdown, a debounced press on up_n, dn_n or store_n clears shdn_o and restores the earlier tap with no immediate step. If a movement button stays held, stepping starts SLOW_TICKS ticks later.
- R9: While freeze is 1, no step changes the tap and step_o stays 0.
- R10: load_en=1 at a clock edge sets the tap to load_val at that edge, even while frozen. step_o is high for one cycle on every step that changes the tap and never when the tap does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_n | input | 1 | Raise button, active low |
| dn_n | input | 1 | Lower button, active low |
| store_n | input | 1 | Store button, active low; used here only to wake from shutdown |
| freeze | input | 1 | Block all stepping while high |
| load_en | input | 1 | Load load_val into the position |
| load_val | input | TAP_W | Position to load |
| tap_o | output | TAP_W | Tap code, 0 during shutdown |
| shdn_o | output | 1 | Shutdown flag: disconnect top of chain |
| step_o | output | 1 | One-cycle strobe per tap change by a step |

## Verification
The bench builds the block with DEB_TICKS=4, SLOW_TICKS=20, FAST_AFTER=80, FAST_TICKS=5 and SHDN_TICKS=60. With these values the slow-to-fast switch, the two-button shutdown hold and the repeat intervals all fall within a few hundred cycles. This lets the bench measure exact spacing between strobes in both repeat modes, walk the position to both saturation limits, and run full shutdown entry and exit sequences. TAP_W and RESET_TAP keep their defaults, so the 0 and 31 limits and the reset value of 16 are checked as stated.

// File: rtl/btnw_pkg.sv
package btnw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_HOLD  = 3'd2,
    ST_PAIR  = 3'd3,
    ST_BLOCK = 3'd4,
    ST_SHDN  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/btnw_debounce.sv
module btnw_debounce #(
  parameter int DEB_TICKS = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic pressed,
  output logic press_pulse
);
  localparam int CNT_W = $clog2(DEB_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_TICKS - 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             raw_pressed;
  logic             flip;

  assign raw_pressed = ~sync_q[1];
  assign flip        = (raw_pressed != pressed) && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= 2'b11;
      cnt_q       <= '0;
      pressed     <= 1'b0;
      press_pulse <= 1'b0;
    end else begin
      sync_q      <= {sync_q[0], raw_n};
      press_pulse <= flip && raw_pressed;
      if (raw_pressed == pressed) begin
        cnt_q <= '0;
      end else if (flip) begin
        cnt_q   <= '0;
        pressed <= raw_pressed;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/btnw_seq.sv
module btnw_seq
  import btnw_pkg::*;
#(
  parameter int DEB_TICKS  = 15000,
  parameter int SLOW_TICKS = 250000,
  parameter int FAST_AFTER = 1000000,
  parameter int FAST_TICKS = 50000,
  parameter int SHDN_TICKS = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_prs,
  input  logic dn_prs,
  input  logic up_pls,
  input  logic dn_pls,
  input  logic st_pls,
  output logic step_req,
  output logic step_up,
  output logic shdn
);
  localparam int MAX_A = (DEB_TICKS > SLOW_TICKS) ? DEB_TICKS : SLOW_TICKS;
  localparam int MAX_B = (FAST_AFTER > SHDN_TICKS) ? FAST_AFTER : SHDN_TICKS;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W = $clog2(MAX_T + 1);
  localparam logic [TMR_W-1:0] ARM_LAST  = TMR_W'(DEB_TICKS - 1);
  localparam logic [TMR_W-1:0] SHDN_LAST = TMR_W'(SHDN_TICKS - 1);
  localparam logic [TMR_W-1:0] SLOW_LAST = TMR_W'(SLOW_TICKS - 1);
  localparam logic [TMR_W-1:0] FAST_LAST = TMR_W'(FAST_TICKS - 1);
  localparam logic [TMR_W-1:0] FAST_AT   = TMR_W'(FAST_AFTER);

  seq_state_t       st_q;
  logic             dir_q;
  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] rep_q;
  logic [TMR_W-1:0] held_q;
  logic             own, other, rep_due, arm_fire;

  function automatic logic [TMR_W-1:0] rep_limit(input logic [TMR_W-1:0] held);
    return (held >= FAST_AT) ? FAST_LAST : SLOW_LAST;
  endfunction

  assign own      = dir_q ? up_prs : dn_prs;
  assign other    = dir_q ? dn_prs : up_prs;
  assign rep_due  = rep_q >= rep_limit(held_q);
  assign arm_fire = !other && (!own || (tmr_q == ARM_LAST));
  assign step_up  = dir_q;
  assign shdn     = (st_q == ST_SHDN);

  always_comb begin
    step_req = 1'b0;
    if (st_q == ST_ARM)  step_req = arm_fire;
    if (st_q == ST_HOLD) step_req = !other && own && rep_due;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dir_q  <= 1'b1;
      tmr_q  <= '0;
      rep_q  <= '0;
      held_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          tmr_q  <= '0;
          rep_q  <= '0;
          held_q <= '0;
          if (up_prs && dn_prs) begin
            st_q <= ST_PAIR;
          end else if (up_prs || dn_prs) begin
            st_q  <= ST_ARM;
            dir_q <= up_prs;
          end
        end
        ST_ARM: begin
          if (other) begin
            st_q  <= ST_PAIR;
            tmr_q <= '0;
          end else if (!own) begin
            st_q <= ST_IDLE;
          end else if (tmr_q == ARM_LAST) begin
            st_q   <= ST_HOLD;
            rep_q  <= '0;
            held_q <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (other) begin
            st_q <= ST_BLOCK;
          end else if (!own) begin
            st_q <= ST_IDLE;
          end else begin
            if (held_q < FAST_AT) held_q <= held_q + 1'b1;
            rep_q <= rep_due ? '0 : rep_q + 1'b1;
          end
        end
        ST_PAIR: begin
          if (!(up_prs && dn_prs)) begin
            st_q <= ST_BLOCK;
          end else if (tmr_q == SHDN_LAST) begin
            st_q <= ST_SHDN;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_BLOCK: begin
          if (!up_prs && !dn_prs) st_q <= ST_IDLE;
        end
        ST_SHDN: begin
          rep_q  <= '0;
          held_q <= '0;
          if (up_pls || dn_pls || st_pls) begin
            if (up_prs && dn_prs) begin
              st_q <= ST_BLOCK;
            end else if (up_prs || dn_prs) begin
              st_q  <= ST_HOLD;
              dir_q <= up_prs;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/btnw_pos.sv
module btnw_pos #(
  parameter int TAP_W     = 5,
  parameter int RESET_TAP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_req,
  input  logic             step_up,
  input  logic             freeze,
  input  logic             load_en,
  input  logic [TAP_W-1:0] load_val,
  output logic [TAP_W-1:0] pos,
  output logic             moved
);
  localparam logic [TAP_W-1:0] TOP_CODE = {TAP_W{1'b1}};

  function automatic logic [TAP_W-1:0] sat_step(input logic [TAP_W-1:0] p,
                                                input logic up);
    if (up)  return (p == TOP_CODE) ? p : p + 1'b1;
    return (p == '0) ? p : p - 1'b1;
  endfunction

  logic [TAP_W-1:0] nxt;
  logic             take;

  assign nxt  = sat_step(pos, step_up);
  assign take = step_req && !freeze && (nxt != pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= TAP_W'(RESET_TAP);
      moved <= 1'b0;
    end else if (load_en) begin
      pos   <= load_val;
      moved <= 1'b0;
    end else begin
      moved <= take;
      if (take) pos <= nxt;
    end
  end
endmodule

// File: rtl/btnw_top.sv
module btnw_top #(
  parameter int TAP_W      = 5,
  parameter int RESET_TAP  = 16,
  parameter int DEB_TICKS  = 15000,
  parameter int SLOW_TICKS = 250000,
  parameter int FAST_AFTER = 1000000,
  parameter int FAST_TICKS = 50000,
  parameter int SHDN_TICKS = 2000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_n,
  input  logic             dn_n,
  input  logic             store_n,
  input  logic             freeze,
  input  logic             load_en,
  input  logic [TAP_W-1:0] load_val,
  output logic [TAP_W-1:0] tap_o,
  output logic             shdn_o,
  output logic             step_o
);
  localparam int N_BTN = 3;

  logic [N_BTN-1:0] raw_n, prs, pls;
  logic             step_req, step_up, shdn;
  logic [TAP_W-1:0] pos;

  assign raw_n = {store_n, dn_n, up_n};

  for (genvar i = 0; i < N_BTN; i++) begin : g_deb
    btnw_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw_n      (raw_n[i]),
      .pressed    (prs[i]),
      .press_pulse(pls[i])
    );
  end

  btnw_seq #(
    .DEB_TICKS (DEB_TICKS),
    .SLOW_TICKS(SLOW_TICKS),
    .FAST_AFTER(FAST_AFTER),
    .FAST_TICKS(FAST_TICKS),
    .SHDN_TICKS(SHDN_TICKS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_prs  (prs[0]),
    .dn_prs  (prs[1]),
    .up_pls  (pls[0]),
    .dn_pls  (pls[1]),
    .st_pls  (pls[2]),
    .step_req(step_req),
    .step_up (step_up),
    .shdn    (shdn)
  );

  btnw_pos #(.TAP_W(TAP_W), .RESET_TAP(RESET_TAP)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_req(step_req),
    .step_up (step_up),
    .freeze  (freeze),
    .load_en (load_en),
    .load_val(load_val),
    .pos     (pos),
    .moved   (step_o)
  );

  assign shdn_o = shdn;
  assign tap_o  = shdn ? '0 : pos;
endmodule

// File: rtl/btnw_chk.sv
module btnw_chk #(
  parameter int TAP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             freeze,
  input logic             load_en,
  input logic [TAP_W-1:0] tap_o,
  input logic             shdn_o,
  input logic             step_o,
  input logic             step_req
);
  // R1
  tap_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_en) && !shdn_o && !$past(shdn_o)) |->
      (int'(tap_o) == int'($past(tap_o)) || int'(tap_o) == int'($past(tap_o)) + 1 ||
       int'(tap_o) == int'($past(tap_o)) - 1));

  // R7
  shdn_tap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_o |-> (tap_o == '0));

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(freeze) && !$past(load_en) && (shdn_o == $past(shdn_o))) |-> (tap_o == $past(tap_o)));

  // R9
  freeze_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(freeze) |-> !step_o);

  // R10
  strobe_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> (tap_o != $past(tap_o) && $past(step_req)));

  // R8
  no_step_in_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_o |-> !step_req);
endmodule

bind btnw_top btnw_chk #(.TAP_W(TAP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .freeze  (freeze),
  .load_en (load_en),
  .tap_o   (tap_o),
  .shdn_o  (shdn_o),
  .step_o  (step_o),
  .step_req(step_req)
);

// File: tb/btnw_top_bench.sv
module btnw_top_bench;
  localparam int TW = 5;
  localparam int DEB = 4, SLOW = 20, FAST_AT = 80, FAST = 5, SHDN = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_n = 1'b1, dn_n = 1'b1, store_n = 1'b1;
  logic freeze = 1'b0, load_en = 1'b0;
  logic [TW-1:0] load_val = '0;
  logic [TW-1:0] tap_o;
  logic shdn_o, step_o;

  int checks = 0, errors = 0;
  int cyc = 0, pulses = 0;
  int pt [0:63];

  always #5 clk = ~clk;

  btnw_top #(.TAP_W(TW), .RESET_TAP(16), .DEB_TICKS(DEB), .SLOW_TICKS(SLOW),
             .FAST_AFTER(FAST_AT), .FAST_TICKS(FAST), .SHDN_TICKS(SHDN)) u_btnw_top (
    .clk(clk), .rst_n(rst_n), .up_n(up_n), .dn_n(dn_n), .store_n(store_n),
    .freeze(freeze), .load_en(load_en), .load_val(load_val),
    .tap_o(tap_o), .shdn_o(shdn_o), .step_o(step_o));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && step_o) begin
      if (pulses < 64) pt[pulses] <= cyc;
      pulses <= pulses + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input int v);
    @(negedge clk); load_en = 1'b1; load_val = TW'(v);
    @(negedge clk); load_en = 1'b0;
  endtask

  task automatic press_up(input int n);
    @(negedge clk); up_n = 1'b0; idle(n); up_n = 1'b1; idle(DEB + 6);
  endtask

  task automatic press_dn(input int n);
    @(negedge clk); dn_n = 1'b0; idle(n); dn_n = 1'b1; idle(DEB + 6);
  endtask

  task automatic t_reset;
    check(tap_o == 5'd16, "R1 reset tap", tap_o, 16);
    check(!shdn_o, "R7 reset shdn", shdn_o, 0);
    check(!step_o, "R10 reset strobe", step_o, 0);
  endtask

  task automatic t_glitch;
    int p0 = pulses;
    press_up(DEB - 1);
    check(tap_o == 5'd16, "R2 short glitch tap", tap_o, 16);
    check(pulses == p0, "R2 short glitch strobe", pulses - p0, 0);
  endtask

  task automatic t_single;
    int p0 = pulses;
    press_up(DEB + 6);
    check(tap_o == 5'd17, "R3 up press", tap_o, 17);
    check(pulses == p0 + 1, "R10 one strobe per step", pulses - p0, 1);
    press_dn(DEB + 12);
    check(tap_o == 5'd16, "R3 down press", tap_o, 16);
  endtask

  task automatic t_saturate;
    int p0;
    do_load(31);
    check(tap_o == 5'd31, "R10 load", tap_o, 31);
    p0 = pulses;
    press_up(DEB + 6);
    check(tap_o == 5'd31, "R1 top saturation", tap_o, 31);
    check(pulses == p0, "R10 no strobe at limit", pulses - p0, 0);
    do_load(0);
    press_dn(DEB + 6);
    check(tap_o == 5'd0, "R1 bottom saturation", tap_o, 0);
  endtask

  task automatic t_repeat;
    int p0, n, p1;
    do_load(0);
    p0 = pulses;
    @(negedge clk); up_n = 1'b0;
    idle(150);
    up_n = 1'b1;
    idle(DEB + 4);
    n = pulses - p0;
    check(n >= 8, "R4 repeat count", n, 8);
    check(pt[p0 + 1] - pt[p0] == SLOW, "R4 slow period", pt[p0 + 1] - pt[p0], SLOW);
    check(pt[p0 + n - 1] - pt[p0 + n - 2] == FAST, "R4 fast period",
          pt[p0 + n - 1] - pt[p0 + n - 2], FAST);
    check(int'(tap_o) == n, "R4 tap equals steps", tap_o, n);
    p1 = pulses;
    idle(3 * SLOW);
    check(pulses == p1, "R5 stop after release", pulses - p1, 0);
  endtask

  task automatic t_pair_short;
    int p0 = pulses;
    do_load(9);
    @(negedge clk); up_n = 1'b0; dn_n = 1'b0;
    idle(20);
    up_n = 1'b1; dn_n = 1'b1;
    idle(DEB + 6);
    check(tap_o == 5'd9 && pulses == p0, "R7 short pair no move", tap_o, 9);
    check(!shdn_o, "R7 short pair no shutdown", shdn_o, 0);
  endtask

  task automatic t_stagger;
    do_load(9);
    @(negedge clk); up_n = 1'b0;
    idle(15);
    dn_n = 1'b0;
    idle(SHDN + 30);
    check(tap_o == 5'd10, "R6 staggered pair blocks", tap_o, 10);
    check(!shdn_o, "R6 staggered pair no shutdown", shdn_o, 0);
    up_n = 1'b1; dn_n = 1'b1;
    idle(DEB + 6);
  endtask

  task automatic enter_shdn;
    @(negedge clk); up_n = 1'b0; dn_n = 1'b0;
    idle(SHDN + 20);
    up_n = 1'b1; dn_n = 1'b1;
    idle(DEB + 6);
  endtask

  task automatic t_shdn_store;
    do_load(10);
    enter_shdn();
    check(shdn_o, "R7 shutdown entered", shdn_o, 1);
    check(tap_o == 5'd0, "R7 tap forced low", tap_o, 0);
    @(negedge clk); store_n = 1'b0;
    idle(DEB + 6);
    store_n = 1'b1;
    idle(DEB + 6);
    check(!shdn_o, "R8 store wakes", shdn_o, 1'b0);
    check(tap_o == 5'd10, "R8 tap restored", tap_o, 10);
  endtask

  task automatic t_shdn_up;
    enter_shdn();
    @(negedge clk); up_n = 1'b0;
    idle(12);
    check(!shdn_o && tap_o == 5'd10, "R8 wake no immediate step", tap_o, 10);
    idle(28);
    check(tap_o == 5'd11, "R8 repeat after slow period", tap_o, 11);
    up_n = 1'b1;
    idle(DEB + 6);
  endtask

  task automatic t_freeze;
    int p0;
    do_load(20);
    @(negedge clk); freeze = 1'b1;
    p0 = pulses;
    press_up(DEB + 6);
    check(tap_o == 5'd20, "R9 freeze blocks step", tap_o, 20);
    check(pulses == p0, "R9 freeze no strobe", pulses - p0, 0);
    do_load(7);
    check(tap_o == 5'd7, "R10 load while frozen", tap_o, 7);
    @(negedge clk); freeze = 1'b0;
    press_dn(DEB + 6);
    check(tap_o == 5'd6, "R9 unfreeze steps again", tap_o, 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_glitch();
    t_single();
    t_saturate();
    t_repeat();
    t_pair_short();
    t_stagger();
    t_shdn_store();
    t_shdn_up();
    t_freeze();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule